// File: doc/BRIEF.md
# Gated Multi-Function Execute Unit

This block is the execute stage of a small integer datapath. Each cycle it can accept two 16-bit operands and a 3-bit operation code. It can compute a bitwise AND, OR or XOR, a 16-bit sum, or the signed product of the two low bytes. Every sub-unit result is captured in a register of its own. A multiplexer after those registers, keyed on the captured operation code, drives the result port. The result is therefore due on the clock edge after the operation is accepted.

The three bitwise operations share one logic sub-unit. That sub-unit's register loads only when one of its own operations is accepted; at all other times it keeps its old value. The adder is a chain of ripple-carry full-adder cells. The multiplier treats the low byte of each operand as a two's-complement number and returns the full 16-bit product. A global clock enable freezes the whole unit while it is low.

Top module: `gated_alu_exec`

## Requirements
- R1: While `rst_n` is low, `result` reads 0 and `res_vld` reads 0.
- R2: With `clk_en` and `in_vld` high, the codes 000 (AND), 001 (OR) and 010 (XOR) give the bitwise function of `op_a` and `op_b` on `result` after the next rising edge.
- R3: Code 011 gives `op_a + op_b` modulo 2^16 after the next edge; any carry out of bit 15 is discarded.
- R4: Code 100 gives the signed product of `op_a[7:0]` and `op_b[7:0]` as a 16-bit two's-complement value after the next edge; bits 15:8 of both operands are ignored.
- R5: An accepted code from 101 to 111 sets `result` to 0 and `res_vld` to 0 after the next edge.
- R6: `res_vld` is high after an edge exactly when, at that edge, `clk_en` and `in_vld` were high and the code was in the range 000 to 100.
- R7: While `clk_en` is low, `result` and `res_vld` keep their values and all other inputs are ignored.
- R8: An edge with `clk_en` high and `in_vld` low clears `res_vld` and leaves `result` unchanged. The logic sub-unit's register changes only on an accepted code 000, 001 or 010.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Global enable; low freezes all state |
| in_vld | input | 1 | Operands and code are presented this cycle |
| opcode | input | 3 | Operation select (000 AND, 001 OR, 010 XOR, 011 ADD, 100 MUL) |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| result | output | 16 | Registered result of the last accepted operation |
| res_vld | output | 1 | Result of a legal accepted operation is present |

## Verification
Every operation has a latency of one cycle. Inputs are driven on a falling edge and captured on the next rising edge. The bench compares `result` and `res_vld` on the falling edge after that, so each comparison falls half a period after the register that produces it has loaded. Hold cases follow the same rule: the bench predicts an unchanged value for the cycle after a frozen or idle edge. It then samples on the falling edge, before any later stimulus can move the output.

// File: rtl/alu_pkg.sv
package alu_pkg;

    parameter int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_AND = 3'b000,
        OP_OR  = 3'b001,
        OP_XOR = 3'b010,
        OP_ADD = 3'b011,
        OP_MUL = 3'b100
    } alu_op_e;

    function automatic logic op_legal(input logic [OP_W-1:0] code);
        return code <= OP_MUL;
    endfunction

    function automatic logic op_is_logic(input logic [OP_W-1:0] code);
        return code <= OP_XOR;
    endfunction

endpackage

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [1:0]   fsel,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] q
);

    logic [W-1:0] logic_d;
    logic [W-1:0] logic_q;

    always_comb begin
        logic_d = logic_q;
        if (load) begin
            case (fsel)
                2'b00:   logic_d = a & b;
                2'b01:   logic_d = a | b;
                2'b10:   logic_d = a ^ b;
                default: logic_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) logic_q <= '0;
        else        logic_q <= logic_d;
    end

    assign q = logic_q;

endmodule

// File: rtl/alu_ripple_adder.sv
module alu_ripple_adder #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum
);

    logic [W-1:0] carry;

    assign carry[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_cell
        assign sum[i] = a[i] ^ b[i] ^ carry[i];
        if (i < W - 1) begin : g_carry
            assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
        end
    end

endmodule

// File: rtl/alu_smul.sv
module alu_smul #(
    parameter int IW = 8,
    parameter int OW = 16
) (
    input  logic [IW-1:0] a,
    input  logic [IW-1:0] b,
    output logic [OW-1:0] p
);

    logic signed [IW-1:0] a_s;
    logic signed [IW-1:0] b_s;
    logic signed [OW-1:0] a_x;
    logic signed [OW-1:0] b_x;

    assign a_s = a;
    assign b_s = b;
    assign a_x = OW'(a_s);
    assign b_x = OW'(b_s);
    assign p   = a_x * b_x;

endmodule

// File: rtl/gated_alu_exec.sv
module gated_alu_exec
    import alu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int MUL_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              in_vld,
    input  logic [OP_W-1:0]   opcode,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic [DATA_W-1:0] result,
    output logic              res_vld
);

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic              vld;
        logic [DATA_W-1:0] sum;
        logic [DATA_W-1:0] prod;
    } exec_st_t;

    exec_st_t          st_d, st_q;
    logic              take;
    logic              logic_load;
    logic [DATA_W-1:0] sum_w;
    logic [DATA_W-1:0] prod_w;
    logic [DATA_W-1:0] logic_q;
    logic [DATA_W-1:0] res_mux;

    assign take       = clk_en & in_vld;
    assign logic_load = take & op_is_logic(opcode);

    alu_logic_unit #(.W(DATA_W)) u_logic (
        .clk  (clk),
        .rst_n(rst_n),
        .load (logic_load),
        .fsel (opcode[1:0]),
        .a    (op_a),
        .b    (op_b),
        .q    (logic_q)
    );

    alu_ripple_adder #(.W(DATA_W)) u_add (
        .a  (op_a),
        .b  (op_b),
        .sum(sum_w)
    );

    alu_smul #(.IW(MUL_W), .OW(DATA_W)) u_mul (
        .a(op_a[MUL_W-1:0]),
        .b(op_b[MUL_W-1:0]),
        .p(prod_w)
    );

    always_comb begin
        st_d = st_q;
        if (clk_en) begin
            st_d.vld = in_vld & op_legal(opcode);
            if (in_vld) begin
                st_d.op = opcode;
                if (opcode == OP_ADD) st_d.sum  = sum_w;
                if (opcode == OP_MUL) st_d.prod = prod_w;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (st_q.op)
            OP_AND, OP_OR, OP_XOR: res_mux = logic_q;
            OP_ADD:                res_mux = st_q.sum;
            OP_MUL:                res_mux = st_q.prod;
            default:               res_mux = '0;
        endcase
    end

    assign result  = res_mux;
    assign res_vld = st_q.vld;

endmodule

// File: rtl/gated_alu_exec_chk.sv
module gated_alu_exec_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         clk_en,
    input logic         in_vld,
    input logic [2:0]   opcode,
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic [W-1:0] result,
    input logic         res_vld,
    input logic [W-1:0] logic_q
);

    always @(negedge clk) begin
        if (!rst_n) begin
            assert_reset_quiet_R1: assert (result == '0 && res_vld == 1'b0);
        end
    end

    property p_vld_set;
        @(posedge clk) disable iff (!rst_n)
        (clk_en && in_vld && opcode <= 3'd4) |=> res_vld;
    endproperty
    assert_vld_set_R6: assert property (p_vld_set);

    property p_vld_clr;
        @(posedge clk) disable iff (!rst_n)
        (clk_en && !(in_vld && opcode <= 3'd4)) |=> !res_vld;
    endproperty
    assert_vld_clr_R6: assert property (p_vld_clr);

    property p_add;
        @(posedge clk) disable iff (!rst_n)
        (clk_en && in_vld && opcode == 3'd3) |=>
            result == W'($past(op_a) + $past(op_b));
    endproperty
    assert_add_wrap_R3: assert property (p_add);

    property p_illegal;
        @(posedge clk) disable iff (!rst_n)
        (clk_en && in_vld && opcode > 3'd4) |=> result == '0;
    endproperty
    assert_illegal_zero_R5: assert property (p_illegal);

    property p_freeze;
        @(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(result) && $stable(res_vld));
    endproperty
    assert_freeze_R7: assert property (p_freeze);

    property p_idle;
        @(posedge clk) disable iff (!rst_n)
        (clk_en && !in_vld) |=> $stable(result);
    endproperty
    assert_idle_hold_R8: assert property (p_idle);

    property p_logic_gated;
        @(posedge clk) disable iff (!rst_n)
        !(clk_en && in_vld && opcode <= 3'd2) |=> $stable(logic_q);
    endproperty
    assert_logic_gated_R8: assert property (p_logic_gated);

endmodule

bind gated_alu_exec gated_alu_exec_chk #(.W(DATA_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .clk_en (clk_en),
    .in_vld (in_vld),
    .opcode (opcode),
    .op_a   (op_a),
    .op_b   (op_b),
    .result (result),
    .res_vld(res_vld),
    .logic_q(logic_q)
);

// File: tb/gated_alu_exec_test.sv
`timescale 1ns/1ps
module gated_alu_exec_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en = 1'b0;
    logic        in_vld = 1'b0;
    logic [2:0]  opcode = 3'd0;
    logic [15:0] op_a = 16'd0;
    logic [15:0] op_b = 16'd0;
    logic [15:0] result;
    logic        res_vld;

    int          n_cmp = 0;
    int          n_bad = 0;
    logic [15:0] exp_res = 16'd0;
    logic        exp_vld = 1'b0;
    logic [31:0] lfsr = 32'hACE1_2468;

    always #10 clk = ~clk;

    gated_alu_exec uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .clk_en (clk_en),
        .in_vld (in_vld),
        .opcode (opcode),
        .op_a   (op_a),
        .op_b   (op_b),
        .result (result),
        .res_vld(res_vld)
    );

    function automatic logic [15:0] model(input logic [2:0] op,
                                          input logic [15:0] a,
                                          input logic [15:0] b);
        logic signed [15:0] sa;
        logic signed [15:0] sb;
        sa = 16'($signed(a[7:0]));
        sb = 16'($signed(b[7:0]));
        case (op)
            3'd0:    return a & b;
            3'd1:    return a | b;
            3'd2:    return a ^ b;
            3'd3:    return 16'(a + b);
            3'd4:    return 16'(sa * sb);
            default: return 16'd0;
        endcase
    endfunction

    function automatic logic [15:0] rnd16();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        return lfsr[23:8];
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Called on a falling edge: drives inputs, predicts, samples on the next falling edge.
    task automatic step(input logic en, input logic v, input logic [2:0] op,
                        input logic [15:0] a, input logic [15:0] b);
        string tag;
        clk_en = en; in_vld = v; opcode = op; op_a = a; op_b = b;
        if (!en)          tag = "R7";
        else if (!v)      tag = "R8";
        else if (op < 3)  tag = "R2";
        else if (op == 3) tag = "R3";
        else if (op == 4) tag = "R4";
        else              tag = "R5";
        if (en) begin
            exp_vld = v && (op <= 3'd4);
            if (v) exp_res = model(op, a, b);
        end
        @(negedge clk);
        check(tag, result, exp_res);
        if (en) check("R6", {15'd0, res_vld}, {15'd0, exp_vld});
        else    check("R7", {15'd0, res_vld}, {15'd0, exp_vld});
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [15:0] corner [6];
        corner[0] = 16'h0000; corner[1] = 16'hFFFF; corner[2] = 16'h8000;
        corner[3] = 16'h7FFF; corner[4] = 16'h00FF; corner[5] = 16'hA55A;

        repeat (3) @(negedge clk);
        check("R1", result, 16'd0);
        check("R1", {15'd0, res_vld}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2..R5: every code with corner operands and random operands
        for (int op = 0; op < 8; op++) begin
            for (int i = 0; i < 6; i++)
                for (int j = 0; j < 6; j++)
                    step(1'b1, 1'b1, 3'(op), corner[i], corner[j]);
            for (int k = 0; k < 64; k++)
                step(1'b1, 1'b1, 3'(op), rnd16(), rnd16());
        end

        // R3: carry out of bit 15 discarded
        step(1'b1, 1'b1, 3'd3, 16'hFFFF, 16'h0001);
        step(1'b1, 1'b1, 3'd3, 16'h8000, 16'h8000);

        // R4: exhaustive low-byte sweep with random upper bytes
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b++)
                step(1'b1, 1'b1, 3'd4, {rnd16() [15:8], 8'(a)}, {rnd16() [7:0], 8'(b)});

        // R7: freeze with legal, logic and illegal codes presented
        step(1'b1, 1'b1, 3'd2, 16'h1234, 16'h0F0F);
        step(1'b0, 1'b1, 3'd3, 16'h1111, 16'h2222);
        step(1'b0, 1'b1, 3'd0, 16'hFFFF, 16'h0000);
        step(1'b0, 1'b1, 3'd7, 16'h5555, 16'hAAAA);
        step(1'b0, 1'b0, 3'd1, 16'h0001, 16'h0002);

        // R8: idle cycles hold result and clear valid
        step(1'b1, 1'b1, 3'd4, 16'h00FE, 16'h0003);
        step(1'b1, 1'b0, 3'd0, 16'hFFFF, 16'hFFFF);
        step(1'b1, 1'b0, 3'd3, 16'h1234, 16'h4321);
        // R8: logic register untouched by ADD/MUL/illegal/idle traffic
        step(1'b1, 1'b1, 3'd1, 16'hF000, 16'h000F);
        step(1'b1, 1'b1, 3'd3, 16'h0101, 16'h0202);
        step(1'b1, 1'b1, 3'd4, 16'h0007, 16'h00F9);
        step(1'b1, 1'b1, 3'd6, 16'h3333, 16'h4444);
        step(1'b1, 1'b0, 3'd2, 16'h0000, 16'h0000);
        step(1'b1, 1'b1, 3'd2, 16'hFF00, 16'h0FF0);

        // R5 then R6: illegal code followed by a legal one
        step(1'b1, 1'b1, 3'd5, 16'hFFFF, 16'hFFFF);
        step(1'b1, 1'b1, 3'd0, 16'hFFFF, 16'h00FF);

        summary();
    end

endmodule